// File: doc/BRIEF.md
# Count/Compare Interval Timer

A free-running up-counter and a match register, both software-writable, that raise a timer interrupt when the counter steps onto the match value. A clock prescaler sets the counter rate: one increment every `TICK_DIV` clock cycles. With a 400 MHz core clock and `TICK_DIV = 4`, the counter advances every 10 ns, which is 100 MHz.

The interrupt goes to one of `N_LINES` output lines. A small selector input, normally a field of the core's interrupt-control register, picks the line. Once raised, the line stays high until software writes the match register. That write also acknowledges the interrupt.

A separate pending flag mirrors the interrupt only when the newer-revision mode input is set. A freeze input stops the counter and its prescaler phase in place. While frozen, the counter can still be loaded, and no match can occur.

Top module: `tick_timer`

## Requirements
- R1: After synchronous reset, `count_o` and `compare_o` are 0 and `irq_o` and `pend_o` are 0.
- R2: While `freeze` is low and no counter write occurs, `count_o` increments by one every `TICK_DIV` clock cycles. It wraps modulo 2^W.
- R3: A counter write is visible on `count_o` in the next cycle and takes priority over an increment. It restarts the prescaler, so the first increment after it comes `TICK_DIV` cycles later.
- R4: When an increment makes `count_o` equal to `compare_o`, the interrupt is raised in the same cycle in which the new count appears. Loading the counter with a value equal to `compare_o` does not raise it.
- R5: The interrupt is driven on bit `line_sel` of `irq_o` only, so `irq_o` is one-hot or zero. A change of `line_sel` moves the line one cycle later.
- R6: Once raised, the interrupt stays high while the count moves past the match value, until a compare write occurs.
- R7: A compare write is visible on `compare_o` in the next cycle. In that same cycle `irq_o` and `pend_o` are both low.
- R8: `pend_o` is set together with the interrupt only when `rev2` is high at the match. `irq_o` is raised in both modes.
- R9: While `freeze` is high, `count_o` and the prescaler phase hold, and no match is raised. Counter writes are still stored. After `freeze` falls, counting resumes from the held count and phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze | input | 1 | Holds the counter and prescaler |
| rev2 | input | 1 | Enables the pending flag |
| line_sel | input | SEL_W | Index of the interrupt line |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | W | Counter write value |
| cmp_we | input | 1 | Compare write strobe (acknowledge) |
| cmp_wdata | input | W | Compare write value |
| count_o | output | W | Current counter value |
| compare_o | output | W | Current compare value |
| irq_o | output | N_LINES | Interrupt lines, at most one high |
| pend_o | output | 1 | Timer interrupt pending flag |

## Verification
A prescaler phase that is off by one shows up on `count_o` within `TICK_DIV` cycles of any counter write, and it moves the interrupt edge by a cycle. A lost or stuck hit flag shows at the acknowledge or on the cycle after a match. In both cases `irq_o` disagrees with the expected line within one cycle. The bench loads the counter near wrap-around and sweeps match distance, line index, mode and freeze windows. At every cycle it compares count, line and pending flag against values computed from the number of unfrozen cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned TMR_W_DEF    = 32;
  localparam int unsigned TICK_DIV_DEF = 4;
  localparam int unsigned N_LINES_DEF  = 8;

  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned DIV = tmr_pkg::TICK_DIV_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase_q;

      always_ff @(posedge clk) begin
        if (rst || restart) begin
          phase_q <= '0;
        end else if (run) begin
          phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
      end

      assign tick = run && (phase_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int unsigned W = tmr_pkg::TMR_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_wdata,
  output logic [W-1:0] count_q,
  output logic [W-1:0] compare_q,
  output logic         fire
);
  logic [W-1:0] count_inc;

  assign count_inc = count_q + 1'b1;
  // a hit needs an increment landing on the match value; writes suppress it
  assign fire = tick && !cnt_we && !cmp_we && (count_inc == compare_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (cnt_we) begin
      count_q <= cnt_wdata;
    end else if (tick) begin
      count_q <= count_inc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      compare_q <= '0;
    end else if (cmp_we) begin
      compare_q <= cmp_wdata;
    end
  end
endmodule

// File: rtl/tmr_route.sv
module tmr_route #(
  parameter int unsigned N_LINES = tmr_pkg::N_LINES_DEF,
  parameter int unsigned SEL_W   = tmr_pkg::sel_width(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  logic               ack,
  input  logic               rev2,
  input  logic [SEL_W-1:0]   line_sel,
  output logic [N_LINES-1:0] irq_q,
  output logic               pend_q
);
  logic hit_q;
  logic hit_n;

  assign hit_n = !ack && (hit_q || fire);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      hit_q <= hit_n;
      if (ack) begin
        pend_q <= 1'b0;
      end else if (fire && rev2) begin
        pend_q <= 1'b1;
      end
    end
  end

  generate
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
      always_ff @(posedge clk) begin
        if (rst) begin
          irq_q[i] <= 1'b0;
        end else begin
          irq_q[i] <= hit_n && (line_sel == SEL_W'(i));
        end
      end
    end
  endgenerate
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int unsigned W        = tmr_pkg::TMR_W_DEF,
  parameter int unsigned TICK_DIV = tmr_pkg::TICK_DIV_DEF,
  parameter int unsigned N_LINES  = tmr_pkg::N_LINES_DEF,
  parameter int unsigned SEL_W    = tmr_pkg::sel_width(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               freeze,
  input  logic               rev2,
  input  logic [SEL_W-1:0]   line_sel,
  input  logic               cnt_we,
  input  logic [W-1:0]       cnt_wdata,
  input  logic               cmp_we,
  input  logic [W-1:0]       cmp_wdata,
  output logic [W-1:0]       count_o,
  output logic [W-1:0]       compare_o,
  output logic [N_LINES-1:0] irq_o,
  output logic               pend_o
);
  logic tick;
  logic fire;

  tmr_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (!freeze),
    .restart (cnt_we),
    .tick    (tick)
  );

  tmr_core #(.W(W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cnt_we    (cnt_we),
    .cnt_wdata (cnt_wdata),
    .cmp_we    (cmp_we),
    .cmp_wdata (cmp_wdata),
    .count_q   (count_o),
    .compare_q (compare_o),
    .fire      (fire)
  );

  tmr_route #(.N_LINES(N_LINES), .SEL_W(SEL_W)) u_route (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .ack      (cmp_we),
    .rev2     (rev2),
    .line_sel (line_sel),
    .irq_q    (irq_o),
    .pend_q   (pend_o)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned W       = 32,
  parameter int unsigned N_LINES = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               freeze,
  input logic               rev2,
  input logic               cnt_we,
  input logic               cmp_we,
  input logic [W-1:0]       count_o,
  input logic [W-1:0]       compare_o,
  input logic [N_LINES-1:0] irq_o,
  input logic               pend_o
);
  logic any_irq;
  assign any_irq = |irq_o;

  a_r5_onehot_line: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_o));

  a_r4_rise_on_match: assert property (@(posedge clk) disable iff (rst)
    $rose(any_irq) |-> (count_o == compare_o));

  a_r6_line_held: assert property (@(posedge clk) disable iff (rst)
    (any_irq && !cmp_we) |=> any_irq);

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
    cmp_we |=> (!any_irq && !pend_o));

  a_r8_pend_needs_rev2: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_o) |-> $past(rev2));

  a_r8_pend_with_line: assert property (@(posedge clk) disable iff (rst)
    pend_o |-> any_irq);

  a_r9_freeze_holds: assert property (@(posedge clk) disable iff (rst)
    (freeze && !cnt_we) |=> $stable(count_o));
endmodule

bind tick_timer tick_timer_chk #(.W(W), .N_LINES(N_LINES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .freeze    (freeze),
  .rev2      (rev2),
  .cnt_we    (cnt_we),
  .cmp_we    (cmp_we),
  .count_o   (count_o),
  .compare_o (compare_o),
  .irq_o     (irq_o),
  .pend_o    (pend_o)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;
  localparam int unsigned W   = 32;
  localparam int unsigned DIV = 2;
  localparam int unsigned NL  = 8;
  localparam int unsigned SW  = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          freeze = 1'b0;
  logic          rev2 = 1'b0;
  logic [SW-1:0] line_sel = '0;
  logic          cnt_we = 1'b0;
  logic [W-1:0]  cnt_wdata = '0;
  logic          cmp_we = 1'b0;
  logic [W-1:0]  cmp_wdata = '0;
  logic [W-1:0]  count_o;
  logic [W-1:0]  compare_o;
  logic [NL-1:0] irq_o;
  logic          pend_o;

  int total_n = 0;
  int fail_n  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  tick_timer #(.W(W), .TICK_DIV(DIV), .N_LINES(NL), .SEL_W(SW)) uut (
    .clk(clk), .rst(rst), .freeze(freeze), .rev2(rev2), .line_sel(line_sel),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .count_o(count_o), .compare_o(compare_o), .irq_o(irq_o), .pend_o(pend_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total_n++;
    if (!ok) begin
      fail_n++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // load count V and compare V+d, run with a freeze pattern, then acknowledge
  task automatic trial(input logic [W-1:0] v, input int d, input int sel,
                       input bit r2, input logic [31:0] fmask, input int steps);
    logic [W-1:0] c;
    logic [NL-1:0] exp_irq;
    int a;
    c = v + W'(d);
    @(negedge clk);
    rev2 = r2; line_sel = SW'(sel);
    cnt_we = 1'b1; cnt_wdata = v; cmp_we = 1'b1; cmp_wdata = c;
    @(negedge clk);
    cnt_we = 1'b0; cmp_we = 1'b0;
    chk(count_o == v, "R3 count load", 64'(count_o), 64'(v));
    chk(compare_o == c, "R7 compare load", 64'(compare_o), 64'(c));
    chk(irq_o == '0 && !pend_o, "R7 clear on compare write", 64'(irq_o), 64'd0);
    a = 0;
    for (int s = 0; s < steps; s++) begin
      freeze = (s < 32) ? fmask[s] : 1'b0;
      @(negedge clk);
      if (!freeze) a++;
      exp_irq = (d > 0 && a >= d * DIV) ? NL'(1) << sel : '0;
      chk(count_o == v + W'(a / DIV), freeze ? "R9 freeze count" : "R2 count rate",
          64'(count_o), 64'(v + W'(a / DIV)));
      chk(irq_o == exp_irq, (a > d * DIV) ? "R6 line held" : "R4 R5 match line",
          64'(irq_o), 64'(exp_irq));
      chk(pend_o == (r2 && exp_irq != '0), "R8 pending by mode",
          64'(pend_o), 64'(r2 && exp_irq != '0));
    end
    freeze = 1'b0;
    cmp_we = 1'b1; cmp_wdata = c - 1'b1;
    @(negedge clk);
    cmp_we = 1'b0;
    chk(irq_o == '0 && !pend_o, "R7 acknowledge", 64'({pend_o, irq_o}), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total_n++; fail_n++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", total_n - fail_n, total_n);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(count_o == '0 && compare_o == '0, "R1 reset regs", 64'(count_o), 64'd0);
    chk(irq_o == '0 && !pend_o, "R1 reset irq", 64'({pend_o, irq_o}), 64'd0);
    rst = 1'b0;

    // sweep distance, line and mode, starting near wrap-around
    for (int d = 1; d <= 6; d++)
      for (int sel = 0; sel < NL; sel++)
        for (int r = 0; r < 2; r++)
          trial(32'hFFFF_FFFC + W'(sel), d, sel, r[0], 32'd0, d * DIV + 3);

    // R4: loading count equal to compare gives no hit
    trial(32'h0000_1234, 0, 3, 1'b1, 32'd0, 12);

    // R9: freeze windows at several phases
    trial(32'h10, 3, 5, 1'b1, 32'h0000_000C, 3 * DIV + 6);
    trial(32'h20, 2, 1, 1'b0, 32'h0000_0071, 2 * DIV + 8);
    trial(32'h30, 4, 6, 1'b1, 32'h00FF_0002, 4 * DIV + 14);

    // R9: count write while frozen is stored and held
    @(negedge clk);
    freeze = 1'b1; cnt_we = 1'b1; cnt_wdata = 32'hABCD_0000;
    @(negedge clk);
    cnt_we = 1'b0;
    chk(count_o == 32'hABCD_0000, "R9 write while frozen", 64'(count_o), 64'hABCD_0000);
    repeat (5) @(negedge clk);
    chk(count_o == 32'hABCD_0000, "R9 frozen hold", 64'(count_o), 64'hABCD_0000);
    freeze = 1'b0;

    // R5: moving the selector moves the raised line one cycle later
    trial(32'h40, 1, 2, 1'b0, 32'd0, DIV);
    cmp_we = 1'b1; cmp_wdata = 32'h41;
    cnt_we = 1'b1; cnt_wdata = 32'h40; line_sel = 3'd2;
    @(negedge clk);
    cmp_we = 1'b0; cnt_we = 1'b0;
    repeat (DIV) @(negedge clk);
    chk(irq_o == 8'h04, "R5 line 2", 64'(irq_o), 64'h04);
    line_sel = 3'd7;
    @(negedge clk);
    chk(irq_o == 8'h80, "R5 line moved", 64'(irq_o), 64'h80);

    done = 1'b1;
    $display("%0d/%0d checks passed", total_n - fail_n, total_n);
    $finish;
  end
endmodule